// File: doc/BRIEF.md
# Float to Fixed-Point Converter

This block turns one IEEE-754 single-precision value into a fixed-point integer. The result is held in a 16-bit or a 32-bit container and can be signed or unsigned. The caller chooses how many fraction bits the result carries through a 5-bit immediate code. The block scales the float by two raised to that fraction count and then truncates toward zero. When the scaled value cannot be represented, the result saturates to the container's limit and the invalid flag is raised. When nonzero bits are dropped from a result that is otherwise in range, the inexact flag is raised.

The datapath is combinational and the result is registered once. A request is presented with `in_valid` high, and the result appears one clock later with `out_valid` high. A halfword result fills the whole 32-bit output: it is sign-extended for signed conversions and zero-extended for unsigned ones. The flags describe only the latest conversion, so nothing from an earlier request carries into a new one.

Top module: `f2fx_conv`

## Requirements
- R1: The immediate value is k = {in_imm[3:0], in_imm[4]}, so in_imm[4] becomes its least-significant bit. The fraction-bit count is 16 − k for a halfword container (in_word = 0) and 32 − k for a word container (in_word = 1). When k is larger than the container width, the count is 0.
- R2: The result is the input multiplied by 2^fbits and truncated toward zero, written in two's complement.
- R3: For signed halfword conversions, an exact scaled value above 32767 returns 0x00007FFF and one below −32768 returns 0xFFFF8000, both with invalid set. In-range results are sign-extended from bit 15.
- R4: For signed word conversions, an exact scaled value above 2^31−1 returns 0x7FFFFFFF and one below −2^31 returns 0x80000000, both with invalid set.
- R5: For unsigned conversions, any negative nonzero input returns 0 with invalid set. An exact scaled value above 65535 (halfword) or 2^32−1 (word) returns that maximum with invalid set. Halfword results are zero-extended. Negative zero returns 0 with no flag set.
- R6: A NaN input returns 0 with invalid set. An infinity saturates to the limit that matches its sign, with invalid set.
- R7: Inexact is set exactly when truncation drops nonzero bits and invalid is clear. An exact in-range conversion sets no flag.
- R8: A denormal input is converted from its exact value. With any fraction count it truncates to 0 and sets inexact, except in the unsigned negative case, which falls under R5.
- R9: out_valid is in_valid delayed by one clock. While in_valid is low, the output data and flags hold their values. Reset clears out_valid, out_data and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_float | input | 32 | Single-precision operand |
| in_signed | input | 1 | 1 = signed result, 0 = unsigned |
| in_word | input | 1 | 1 = 32-bit container, 0 = 16-bit container |
| in_imm | input | 5 | Encoded immediate that sets the fraction-bit count |
| out_valid | output | 1 | Result strobe, one clock after the request |
| out_data | output | 32 | Fixed-point result, extended to 32 bits |
| out_invalid | output | 1 | Saturation or NaN occurred |
| out_inexact | output | 1 | Nonzero bits were truncated with no saturation |

## Verification
The properties assume that the control inputs are known whenever in_valid is high. They also assume that a request only has its effect on the clock edge that samples it. The NaN and negative-unsigned properties depend on inputs that are stable through that edge. The bench meets these assumptions by changing the operand and the select bits only on the falling clock edge. It holds in_valid high for exactly one edge per request. It also varies the operand during idle cycles, so the hold behaviour is tested against changing data rather than against a constant input.

// File: rtl/f2fx_pkg.sv
package f2fx_pkg;
    localparam int FLT_W   = 32;
    localparam int EXP_W   = 8;
    localparam int MAN_W   = 23;
    localparam int SIG_W   = MAN_W + 1;
    localparam int BIAS    = 127;
    localparam int WORD_W  = 32;
    localparam int HALF_W  = 16;
    localparam int IMM_W   = 5;
    localparam int FB_W    = $clog2(WORD_W) + 1;
    localparam int SH_W    = 11;
    localparam int MAG_W   = WORD_W + 2;
    localparam int MAX_LSH = MAG_W - SIG_W;

    // Unpacked operand: significand and net binary shift to integer weight
    typedef struct packed {
        logic                 sign;
        logic                 is_nan;
        logic                 is_inf;
        logic                 is_zero;
        logic [SIG_W-1:0]     sig;
        logic [SH_W-1:0]      shamt;   // two's complement
    } unpk_t;

    // Truncated magnitude plus the information needed for range checks
    typedef struct packed {
        logic                 sign;
        logic                 is_nan;
        logic                 is_inf;
        logic                 big;
        logic                 lost;
        logic [MAG_W-1:0]     mag;
    } scl_t;

    typedef struct packed {
        logic [WORD_W-1:0]    data;
        logic                 inv;
        logic                 inx;
    } res_t;

    // Fraction-bit count: container width minus the reordered immediate
    function automatic logic [FB_W-1:0] frac_bits(input logic [IMM_W-1:0] code,
                                                  input logic word);
        logic [IMM_W-1:0] k;
        logic [FB_W-1:0]  cw;
        k  = {code[IMM_W-2:0], code[IMM_W-1]};
        cw = word ? FB_W'(WORD_W) : FB_W'(HALF_W);
        return (FB_W'(k) > cw) ? '0 : cw - FB_W'(k);
    endfunction
endpackage

// File: rtl/f2fx_unpack.sv
module f2fx_unpack
    import f2fx_pkg::*;
(
    input  logic [FLT_W-1:0] flt,
    input  logic [FB_W-1:0]  fbits,
    output unpk_t            u
);
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] man;
    logic [EXP_W-1:0] eff_ex;

    always_comb begin
        ex       = flt[FLT_W-2 -: EXP_W];
        man      = flt[MAN_W-1:0];
        eff_ex   = (ex == '0) ? EXP_W'(1) : ex;
        u.sign   = flt[FLT_W-1];
        u.is_nan = (ex == '1) && (man != '0);
        u.is_inf = (ex == '1) && (man == '0);
        u.is_zero = (ex == '0) && (man == '0);
        u.sig    = {(ex != '0), man};
        u.shamt  = SH_W'(eff_ex) + SH_W'(fbits) - SH_W'(BIAS + MAN_W);
    end
endmodule

// File: rtl/f2fx_scale.sv
module f2fx_scale
    import f2fx_pkg::*;
(
    input  unpk_t u,
    output scl_t  s
);
    logic [SH_W-1:0]    rsh;
    logic [2*SIG_W-1:0] wide;

    always_comb begin
        s.sign   = u.sign;
        s.is_nan = u.is_nan;
        s.is_inf = u.is_inf;
        s.big    = 1'b0;
        s.lost   = 1'b0;
        s.mag    = '0;
        rsh      = '0;
        wide     = '0;
        if (!(u.is_nan || u.is_inf || u.is_zero)) begin
            if (!u.shamt[SH_W-1]) begin
                // left shift: anything past MAX_LSH cannot fit any container
                if (u.shamt > SH_W'(MAX_LSH))
                    s.big = 1'b1;
                else
                    s.mag = MAG_W'(u.sig) << u.shamt;
            end else begin
                rsh = -u.shamt;
                if (rsh > SH_W'(SIG_W)) begin
                    s.lost = |u.sig;
                end else begin
                    wide   = {u.sig, SIG_W'(0)} >> rsh;
                    s.mag  = MAG_W'(wide[2*SIG_W-1:SIG_W]);
                    s.lost = |wide[SIG_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/f2fx_sat.sv
module f2fx_sat
    import f2fx_pkg::*;
(
    input  scl_t s,
    input  logic is_signed,
    input  logic is_word,
    output res_t r
);
    logic [MAG_W-1:0]  lim_pos;
    logic [MAG_W-1:0]  lim_neg;
    logic [MAG_W-1:0]  neg_mag;
    logic [MAG_W-1:0]  neg_lim;
    logic              hi;
    logic              lo;

    always_comb begin
        unique case ({is_signed, is_word})
            2'b11: begin
                lim_pos = (MAG_W'(1) << (WORD_W-1)) - MAG_W'(1);
                lim_neg =  MAG_W'(1) << (WORD_W-1);
            end
            2'b10: begin
                lim_pos = (MAG_W'(1) << (HALF_W-1)) - MAG_W'(1);
                lim_neg =  MAG_W'(1) << (HALF_W-1);
            end
            2'b01: begin
                lim_pos = (MAG_W'(1) << WORD_W) - MAG_W'(1);
                lim_neg = '0;
            end
            default: begin
                lim_pos = (MAG_W'(1) << HALF_W) - MAG_W'(1);
                lim_neg = '0;
            end
        endcase

        // compare the exact value: equal magnitude with dropped bits is beyond
        hi = !s.is_nan && !s.sign &&
             (s.is_inf || s.big || (s.mag > lim_pos) || ((s.mag == lim_pos) && s.lost));
        lo = !s.is_nan && s.sign &&
             (s.is_inf || s.big || (s.mag > lim_neg) || ((s.mag == lim_neg) && s.lost));

        neg_mag = -s.mag;
        neg_lim = -lim_neg;

        if (s.is_nan)   r.data = '0;
        else if (hi)    r.data = lim_pos[WORD_W-1:0];
        else if (lo)    r.data = neg_lim[WORD_W-1:0];
        else if (s.sign) r.data = neg_mag[WORD_W-1:0];
        else            r.data = s.mag[WORD_W-1:0];

        r.inv = s.is_nan | hi | lo;
        r.inx = s.lost & ~r.inv;
    end
endmodule

// File: rtl/f2fx_conv.sv
module f2fx_conv
    import f2fx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [FLT_W-1:0]  in_float,
    input  logic              in_signed,
    input  logic              in_word,
    input  logic [IMM_W-1:0]  in_imm,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_invalid,
    output logic              out_inexact
);
    logic [FB_W-1:0] fbits;
    unpk_t           unpk;
    scl_t            scl;
    res_t            res;

    assign fbits = frac_bits(in_imm, in_word);

    f2fx_unpack u_unpack (.flt(in_float), .fbits(fbits), .u(unpk));
    f2fx_scale  u_scale  (.u(unpk), .s(scl));
    f2fx_sat    u_sat    (.s(scl), .is_signed(in_signed), .is_word(in_word), .r(res));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_data    <= '0;
            out_invalid <= 1'b0;
            out_inexact <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data    <= res.data;
                out_invalid <= res.inv;
                out_inexact <= res.inx;
            end
        end
    end

    p_latency_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_invalid)));

    p_nan_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_float[FLT_W-2 -: EXP_W] == '1) && (in_float[MAN_W-1:0] != '0))
        |=> (out_invalid && (out_data == '0)));

    p_neg_unsigned_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_signed && in_float[FLT_W-1] && (in_float[FLT_W-2:0] != '0))
        |=> (out_invalid && (out_data == '0)));

    p_uhalf_zext_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_signed && !in_word) |=> (out_data[WORD_W-1:HALF_W] == '0));

    p_shalf_sext_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_signed && !in_word) |=>
        (($countones(out_data[WORD_W-1:HALF_W-1]) == 0) ||
         ($countones(out_data[WORD_W-1:HALF_W-1]) == WORD_W-HALF_W+1)));
endmodule

// File: tb/f2fx_conv_tb_top.sv
module f2fx_conv_tb_top;
    localparam int CLK_NS = 5;
    localparam int VW     = 81;
    localparam int NV     = 27;

    // {req, float, signed, word, imm, exp_data, exp_inv, exp_inx}
    // imm code for k: {k[0], k[4:1]}; k=31:11111 k=16:01000 k=0:00000 k=1:10000 k=20:01010 k=3:10001
    localparam logic [VW-1:0] TBL [NV] = '{
        {8'd2, 32'h3FC00000, 1'b1, 1'b1, 5'b11111, 32'h00000003, 1'b0, 1'b0}, // R2 1.5*2
        {8'd2, 32'h40300000, 1'b1, 1'b0, 5'b01000, 32'h00000002, 1'b0, 1'b1}, // R2 truncate
        {8'd3, 32'hC0300000, 1'b1, 1'b0, 5'b01000, 32'hFFFFFFFE, 1'b0, 1'b1}, // R3 toward zero, sext
        {8'd5, 32'h3F800000, 1'b0, 1'b0, 5'b00000, 32'h0000FFFF, 1'b1, 1'b0}, // R5 uhalf max
        {8'd5, 32'h3F000000, 1'b0, 1'b0, 5'b00000, 32'h00008000, 1'b0, 1'b0}, // R5 zext
        {8'd3, 32'h3F000000, 1'b1, 1'b0, 5'b00000, 32'h00007FFF, 1'b1, 1'b0}, // R3 pos sat
        {8'd3, 32'hBF000000, 1'b1, 1'b0, 5'b00000, 32'hFFFF8000, 1'b0, 1'b0}, // R3 exact min
        {8'd3, 32'hBF400000, 1'b1, 1'b0, 5'b00000, 32'hFFFF8000, 1'b1, 1'b0}, // R3 neg sat
        {8'd4, 32'h3F800000, 1'b1, 1'b1, 5'b00000, 32'h7FFFFFFF, 1'b1, 1'b0}, // R4 pos sat
        {8'd4, 32'hBF800000, 1'b1, 1'b1, 5'b10000, 32'h80000000, 1'b0, 1'b0}, // R4 exact min
        {8'd4, 32'hBF800000, 1'b1, 1'b1, 5'b00000, 32'h80000000, 1'b1, 1'b0}, // R4 neg sat
        {8'd5, 32'hBF800000, 1'b0, 1'b1, 5'b11111, 32'h00000000, 1'b1, 1'b0}, // R5 negative
        {8'd5, 32'h3F800000, 1'b0, 1'b1, 5'b00000, 32'hFFFFFFFF, 1'b1, 1'b0}, // R5 uword max
        {8'd2, 32'h3F400000, 1'b0, 1'b1, 5'b10000, 32'h60000000, 1'b0, 1'b0}, // R2 fbits 31
        {8'd6, 32'h7FC00000, 1'b1, 1'b1, 5'b11111, 32'h00000000, 1'b1, 1'b0}, // R6 NaN
        {8'd6, 32'h7F800000, 1'b1, 1'b0, 5'b01000, 32'h00007FFF, 1'b1, 1'b0}, // R6 +inf
        {8'd6, 32'hFF800000, 1'b0, 1'b1, 5'b11111, 32'h00000000, 1'b1, 1'b0}, // R6 -inf unsigned
        {8'd6, 32'hFF800000, 1'b1, 1'b1, 5'b11111, 32'h80000000, 1'b1, 1'b0}, // R6 -inf signed
        {8'd8, 32'h00000001, 1'b1, 1'b1, 5'b00000, 32'h00000000, 1'b0, 1'b1}, // R8 denormal
        {8'd5, 32'h80000000, 1'b0, 1'b0, 5'b01000, 32'h00000000, 1'b0, 1'b0}, // R5 negative zero
        {8'd1, 32'h40400000, 1'b1, 1'b0, 5'b01010, 32'h00000003, 1'b0, 1'b0}, // R1 k>16 clamps
        {8'd1, 32'h3F800000, 1'b1, 1'b0, 5'b10001, 32'h00002000, 1'b0, 1'b0}, // R1 bit order
        {8'd7, 32'h3FFFFFFF, 1'b1, 1'b1, 5'b11111, 32'h00000003, 1'b0, 1'b1}, // R7 inexact
        {8'd5, 32'h477FFF80, 1'b0, 1'b0, 5'b01000, 32'h0000FFFF, 1'b1, 1'b0}, // R5 just above max
        {8'd7, 32'h477FFF00, 1'b0, 1'b0, 5'b01000, 32'h0000FFFF, 1'b0, 1'b0}, // R7 exact no flag
        {8'd8, 32'h80000001, 1'b0, 1'b1, 5'b00000, 32'h00000000, 1'b1, 1'b0}, // R8 neg denormal uns
        {8'd8, 32'h807FFFFF, 1'b1, 1'b0, 5'b01000, 32'h00000000, 1'b0, 1'b1}  // R8 neg denormal signed
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_float;
    logic        in_signed;
    logic        in_word;
    logic [4:0]  in_imm;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_invalid;
    logic        out_inexact;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_NS/2.0) clk = ~clk;

    f2fx_conv dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_float(in_float),
        .in_signed(in_signed), .in_word(in_word), .in_imm(in_imm),
        .out_valid(out_valid), .out_data(out_data),
        .out_invalid(out_invalid), .out_inexact(out_inexact)
    );

    task automatic chk(input string rq, input logic [34:0] act, input logic [34:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
        finish_run();
    end

    initial begin
        logic [34:0] last;
        rst = 1'b1; in_valid = 1'b0; in_float = '0;
        in_signed = 1'b0; in_word = 1'b0; in_imm = '0;
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        chk("R9 reset", {out_valid, out_data, out_invalid, out_inexact}, 35'd0);
        @(negedge clk) rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            in_valid  = 1'b1;
            in_float  = TBL[i][72:41];
            in_signed = TBL[i][40];
            in_word   = TBL[i][39];
            in_imm    = TBL[i][38:34];
            @(posedge clk);
            #1;
            chk($sformatf("R%0d vec%0d", TBL[i][80:73], i),
                {out_valid, out_data, out_invalid, out_inexact},
                {1'b1, TBL[i][33:0]});
        end
        last = {1'b0, TBL[NV-1][33:0]};

        // R9 idle: inputs change, outputs hold, out_valid low
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            in_valid  = 1'b0;
            in_float  = 32'h3F800000 + 32'(j);
            in_signed = j[0];
            in_word   = 1'b1;
            in_imm    = 5'(j);
            @(posedge clk);
            #1;
            chk("R9 idle hold", {out_valid, out_data, out_invalid, out_inexact}, last);
        end

        // R9 back-to-back then idle: valid drops after one cycle
        @(negedge clk);
        in_valid = 1'b1; in_float = 32'h3FC00000; in_signed = 1'b1; in_word = 1'b1; in_imm = 5'b11111;
        @(posedge clk);
        #1;
        chk("R9 latency", {out_valid, out_data, out_invalid, out_inexact}, {1'b1, 32'h3, 2'b00});
        @(negedge clk) in_valid = 1'b0;
        @(posedge clk);
        #1;
        chk("R9 valid drop", {out_valid, out_data, out_invalid, out_inexact}, {1'b0, 32'h3, 2'b00});

        // R9 reset mid-run clears outputs
        @(negedge clk);
        in_valid = 1'b1; in_float = 32'h7FC00000;
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R9 reset midrun", {out_valid, out_data, out_invalid, out_inexact}, 35'd0);
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        @(posedge clk);
        #1;
        finish_run();
    end
endmodule